// File: doc/BRIEF.md
# Address-Space-Tagged Fully Associative Translation Buffer

This block caches page table entries for an address translation path. Each slot holds a virtual page number tag, an address space identifier, a global flag, a physical page number and a small opaque attribute field. A lookup presents a page number together with the current address space identifier. One cycle later the block reports whether a slot matched, the index of that slot, and the physical page and attributes stored in it. Every slot is compared in parallel.

A single maintenance port carries one command per cycle. The commands are:

- insert an entry at the round-robin replacement pointer;
- invalidate everything;
- invalidate every entry that is not global;
- invalidate one page for a given address space;
- read the slot under the pointer, with or without stepping the pointer.

The replacement policy is a plain rotating pointer. Any valid entry in the slot it points at is overwritten without a check. Depth and all field widths are parameters.

Top module: `asid_tlb`

## Requirements
- R1: After synchronous reset every slot is invalid, the replacement pointer is 0, and `rs_vld` and `pk_vld` are low.
- R2: A lookup presented with `lk_valid` high in cycle N produces `rs_vld` high in cycle N+1. `rs_hit` is high only if some slot is valid, has a tag equal to `lk_vpn`, and either has its global flag set or holds an identifier equal to `lk_asid`. On a hit, `rs_idx`, `rs_ppn` and `rs_attr` describe that slot. On a miss, `rs_idx` is 0.
- R3: A non-global entry is missed when the requested identifier differs. A global entry hits for any identifier.
- R4: `mnt_op` = 1 (insert) writes `mnt_vpn`, `mnt_asid`, `mnt_glb`, `mnt_ppn` and `mnt_attr` into the slot under the pointer, marks it valid (overwriting any valid entry there), and steps the pointer by one.
- R5: The pointer steps from DEPTH-1 to 0.
- R6: `mnt_op` = 2 invalidates every slot and sets the pointer to 0.
- R7: `mnt_op` = 3 invalidates every non-global slot. Global slots stay valid.
- R8: `mnt_op` = 4 invalidates every slot that would hit a lookup of `mnt_vpn` with `mnt_asid`, under the R2 rule. All other slots are unchanged, including slots with the same page number under another identifier.
- R9: `mnt_op` = 5 reports, one cycle later on the `pk_*` outputs, the slot under the pointer (index, valid flag and all fields). `mnt_op` = 6 does the same and also steps the pointer. Codes 0 and 7 do nothing.
- R10: When several slots match a lookup, the lowest index is reported.
- R11: A command issued in cycle N affects lookups issued from cycle N+1 on. A lookup issued in cycle N sees the contents from before that command.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| lk_valid | input | 1 | Lookup request |
| lk_vpn | input | VPN_W | Page number to look up |
| lk_asid | input | ASID_W | Current address space identifier |
| mnt_op | input | 3 | Maintenance command code |
| mnt_vpn | input | VPN_W | Page number for insert or page flush |
| mnt_asid | input | ASID_W | Identifier for insert or page flush |
| mnt_glb | input | 1 | Global flag for insert |
| mnt_ppn | input | PPN_W | Physical page for insert |
| mnt_attr | input | ATTR_W | Attribute bits for insert |
| rs_vld | output | 1 | Lookup result valid |
| rs_hit | output | 1 | Lookup hit |
| rs_idx | output | IDX_W | Matching slot index |
| rs_ppn | output | PPN_W | Physical page of the hit |
| rs_attr | output | ATTR_W | Attributes of the hit |
| pk_vld | output | 1 | Pointer-slot read result valid |
| pk_idx | output | IDX_W | Pointer value read |
| pk_used | output | 1 | Valid flag of that slot |
| pk_vpn | output | VPN_W | Tag of that slot |
| pk_asid | output | ASID_W | Identifier of that slot |
| pk_glb | output | 1 | Global flag of that slot |
| pk_ppn | output | PPN_W | Physical page of that slot |
| pk_attr | output | ATTR_W | Attributes of that slot |

## Verification
A stale or spurious valid bit, or a corrupted tag or identifier, is visible at the ports one cycle after the next lookup of that page. It appears as a wrong hit, a wrong index, or a lowest-index choice that changes. A pointer that steps wrongly appears one cycle after the next pointer read. It also shows when a later insert lands in an unexpected slot, so a lookup reports a different index than the rotation predicts. Corrupted payload storage appears only on a hit to that slot, so the bench reads back every slot after filling the whole table and after wrapping the pointer.

// File: rtl/asid_tlb_pkg.sv
package asid_tlb_pkg;

  typedef enum logic [2:0] {
    OP_NONE        = 3'd0,
    OP_INSERT      = 3'd1,
    OP_FLUSH_ALL   = 3'd2,
    OP_FLUSH_LOCAL = 3'd3,
    OP_FLUSH_PAGE  = 3'd4,
    OP_PEEK        = 3'd5,
    OP_PEEK_ADV    = 3'd6
  } tlb_op_e;

endpackage

// File: rtl/tlb_tag_array.sv
module tlb_tag_array #(
  parameter int DEPTH  = 64,
  parameter int VPN_W  = 19,
  parameter int ASID_W = 8,
  localparam int IDX_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clr_all,
  input  logic              clr_local,
  input  logic              clr_page,
  input  logic [VPN_W-1:0]  pg_vpn,
  input  logic [ASID_W-1:0] pg_asid,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [VPN_W-1:0]  wr_vpn,
  input  logic [ASID_W-1:0] wr_asid,
  input  logic              wr_glb,
  input  logic [VPN_W-1:0]  lk_vpn,
  input  logic [ASID_W-1:0] lk_asid,
  output logic [DEPTH-1:0]  lk_match,
  input  logic [IDX_W-1:0]  rd_idx,
  output logic              rd_vld,
  output logic [VPN_W-1:0]  rd_vpn,
  output logic [ASID_W-1:0] rd_asid,
  output logic              rd_glb
);

  logic [DEPTH-1:0]  vld_q;
  logic [DEPTH-1:0]  glb_q;
  logic [VPN_W-1:0]  vpn_q  [DEPTH];
  logic [ASID_W-1:0] asid_q [DEPTH];
  logic [DEPTH-1:0]  pg_match;

  // two comparator rows: one for lookups, one for page invalidation
  for (genvar g = 0; g < DEPTH; g++) begin : g_cmp
    assign lk_match[g] = vld_q[g] && (vpn_q[g] == lk_vpn) &&
                         (glb_q[g] || (asid_q[g] == lk_asid));
    assign pg_match[g] = vld_q[g] && (vpn_q[g] == pg_vpn) &&
                         (glb_q[g] || (asid_q[g] == pg_asid));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      vld_q <= '0;
    end else if (clr_all) begin
      vld_q <= '0;
    end else if (clr_local) begin
      vld_q <= vld_q & glb_q;
    end else if (clr_page) begin
      vld_q <= vld_q & ~pg_match;
    end else if (wr_en) begin
      vld_q[wr_idx] <= 1'b1;
    end
  end

  // tag fields carry no reset; they are qualified by vld_q
  always_ff @(posedge clk) begin
    if (wr_en) begin
      vpn_q[wr_idx]  <= wr_vpn;
      asid_q[wr_idx] <= wr_asid;
      glb_q[wr_idx]  <= wr_glb;
    end
  end

  assign rd_vld  = vld_q[rd_idx];
  assign rd_vpn  = vpn_q[rd_idx];
  assign rd_asid = asid_q[rd_idx];
  assign rd_glb  = glb_q[rd_idx];

endmodule

// File: rtl/tlb_payload_ram.sv
module tlb_payload_ram #(
  parameter int DEPTH  = 64,
  parameter int DATA_W = 26,
  localparam int IDX_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              we,
  input  logic [IDX_W-1:0]  waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [IDX_W-1:0]  ra_addr,
  output logic [DATA_W-1:0] ra_data,
  input  logic [IDX_W-1:0]  rb_addr,
  output logic [DATA_W-1:0] rb_data
);

  logic [DATA_W-1:0] mem [DEPTH];

  // read-before-write: a same-cycle read returns the old word
  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    ra_data <= mem[ra_addr];
    rb_data <= mem[rb_addr];
  end

endmodule

// File: rtl/tlb_first_one.sv
module tlb_first_one #(
  parameter int DEPTH  = 64,
  localparam int IDX_W = $clog2(DEPTH)
) (
  input  logic [DEPTH-1:0] req,
  output logic             any,
  output logic [IDX_W-1:0] idx
);

  always_comb begin
    any = |req;
    idx = '0;
    for (int i = DEPTH - 1; i >= 0; i--) begin
      if (req[i]) idx = IDX_W'(i);
    end
  end

endmodule

// File: rtl/tlb_rr_ptr.sv
module tlb_rr_ptr #(
  parameter int DEPTH  = 64,
  localparam int IDX_W = $clog2(DEPTH),
  localparam logic [IDX_W-1:0] LAST = IDX_W'(DEPTH - 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr,
  input  logic             step,
  output logic [IDX_W-1:0] ptr
);

  logic [IDX_W-1:0] ptr_q;

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      ptr_q <= '0;
    end else if (step) begin
      ptr_q <= (ptr_q == LAST) ? '0 : ptr_q + 1'b1;
    end
  end

  assign ptr = ptr_q;

endmodule

// File: rtl/asid_tlb.sv
module asid_tlb
  import asid_tlb_pkg::*;
#(
  parameter int DEPTH  = 64,
  parameter int VPN_W  = 19,
  parameter int ASID_W = 8,
  parameter int PPN_W  = 20,
  parameter int ATTR_W = 6,
  localparam int IDX_W = $clog2(DEPTH),
  localparam int PAY_W = PPN_W + ATTR_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              lk_valid,
  input  logic [VPN_W-1:0]  lk_vpn,
  input  logic [ASID_W-1:0] lk_asid,
  input  logic [2:0]        mnt_op,
  input  logic [VPN_W-1:0]  mnt_vpn,
  input  logic [ASID_W-1:0] mnt_asid,
  input  logic              mnt_glb,
  input  logic [PPN_W-1:0]  mnt_ppn,
  input  logic [ATTR_W-1:0] mnt_attr,
  output logic              rs_vld,
  output logic              rs_hit,
  output logic [IDX_W-1:0]  rs_idx,
  output logic [PPN_W-1:0]  rs_ppn,
  output logic [ATTR_W-1:0] rs_attr,
  output logic              pk_vld,
  output logic [IDX_W-1:0]  pk_idx,
  output logic              pk_used,
  output logic [VPN_W-1:0]  pk_vpn,
  output logic [ASID_W-1:0] pk_asid,
  output logic              pk_glb,
  output logic [PPN_W-1:0]  pk_ppn,
  output logic [ATTR_W-1:0] pk_attr
);

  tlb_op_e op;
  assign op = tlb_op_e'(mnt_op);

  logic is_ins, is_fall, is_floc, is_fpg, is_peek, is_padv;
  assign is_ins  = (op == OP_INSERT);
  assign is_fall = (op == OP_FLUSH_ALL);
  assign is_floc = (op == OP_FLUSH_LOCAL);
  assign is_fpg  = (op == OP_FLUSH_PAGE);
  assign is_padv = (op == OP_PEEK_ADV);
  assign is_peek = (op == OP_PEEK) || is_padv;

  logic [IDX_W-1:0]  ptr;
  logic [DEPTH-1:0]  match;
  logic              any;
  logic [IDX_W-1:0]  first;
  logic              rd_vld, rd_glb;
  logic [VPN_W-1:0]  rd_vpn;
  logic [ASID_W-1:0] rd_asid;
  logic [PAY_W-1:0]  lk_pay, pk_pay;

  tlb_rr_ptr #(.DEPTH(DEPTH)) u_ptr (
    .clk  (clk),
    .rst  (rst),
    .clr  (is_fall),
    .step (is_ins || is_padv),
    .ptr  (ptr)
  );

  tlb_tag_array #(.DEPTH(DEPTH), .VPN_W(VPN_W), .ASID_W(ASID_W)) u_tags (
    .clk       (clk),
    .rst       (rst),
    .clr_all   (is_fall),
    .clr_local (is_floc),
    .clr_page  (is_fpg),
    .pg_vpn    (mnt_vpn),
    .pg_asid   (mnt_asid),
    .wr_en     (is_ins),
    .wr_idx    (ptr),
    .wr_vpn    (mnt_vpn),
    .wr_asid   (mnt_asid),
    .wr_glb    (mnt_glb),
    .lk_vpn    (lk_vpn),
    .lk_asid   (lk_asid),
    .lk_match  (match),
    .rd_idx    (ptr),
    .rd_vld    (rd_vld),
    .rd_vpn    (rd_vpn),
    .rd_asid   (rd_asid),
    .rd_glb    (rd_glb)
  );

  tlb_first_one #(.DEPTH(DEPTH)) u_enc (
    .req (match),
    .any (any),
    .idx (first)
  );

  tlb_payload_ram #(.DEPTH(DEPTH), .DATA_W(PAY_W)) u_pay (
    .clk     (clk),
    .we      (is_ins),
    .waddr   (ptr),
    .wdata   ({mnt_attr, mnt_ppn}),
    .ra_addr (first),
    .ra_data (lk_pay),
    .rb_addr (ptr),
    .rb_data (pk_pay)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      rs_vld  <= 1'b0;
      rs_hit  <= 1'b0;
      rs_idx  <= '0;
      pk_vld  <= 1'b0;
      pk_idx  <= '0;
      pk_used <= 1'b0;
      pk_vpn  <= '0;
      pk_asid <= '0;
      pk_glb  <= 1'b0;
    end else begin
      rs_vld  <= lk_valid;
      rs_hit  <= lk_valid && any;
      rs_idx  <= any ? first : '0;
      pk_vld  <= is_peek;
      pk_idx  <= ptr;
      pk_used <= rd_vld;
      pk_vpn  <= rd_vpn;
      pk_asid <= rd_asid;
      pk_glb  <= rd_glb;
    end
  end

  assign rs_ppn  = lk_pay[PPN_W-1:0];
  assign rs_attr = lk_pay[PAY_W-1:PPN_W];
  assign pk_ppn  = pk_pay[PPN_W-1:0];
  assign pk_attr = pk_pay[PAY_W-1:PPN_W];

endmodule

// File: rtl/asid_tlb_chk.sv
module asid_tlb_chk #(
  parameter int DEPTH  = 64,
  localparam int IDX_W = $clog2(DEPTH),
  localparam logic [IDX_W-1:0] LAST = IDX_W'(DEPTH - 1)
) (
  input logic             clk,
  input logic             rst,
  input logic [2:0]       mnt_op,
  input logic             rs_vld,
  input logic             rs_hit,
  input logic [IDX_W-1:0] rs_idx,
  input logic             pk_vld,
  input logic [IDX_W-1:0] pk_idx,
  input logic [DEPTH-1:0] vld,
  input logic [DEPTH-1:0] glb,
  input logic [IDX_W-1:0] ptr
);

  p_reset_clean_r1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (vld == '0 && ptr == '0 && !rs_vld && !pk_vld));

  p_hit_has_req_r2: assert property (@(posedge clk) disable iff (rst)
    rs_hit |-> rs_vld);

  p_miss_idx_zero_r2: assert property (@(posedge clk) disable iff (rst)
    (rs_vld && !rs_hit) |-> rs_idx == '0);

  p_insert_sets_r4: assert property (@(posedge clk) disable iff (rst)
    (mnt_op == 3'd1) |=> vld[$past(ptr)]);

  p_insert_step_r4: assert property (@(posedge clk) disable iff (rst)
    (mnt_op == 3'd1 && ptr != LAST) |=> ptr == $past(ptr) + 1'b1);

  p_ptr_wrap_r5: assert property (@(posedge clk) disable iff (rst)
    ((mnt_op == 3'd1 || mnt_op == 3'd6) && ptr == LAST) |=> ptr == '0);

  p_flush_all_r6: assert property (@(posedge clk) disable iff (rst)
    (mnt_op == 3'd2) |=> (vld == '0 && ptr == '0));

  p_flush_local_r7: assert property (@(posedge clk) disable iff (rst)
    (mnt_op == 3'd3) |=> ((vld & ~glb) == '0 && vld == ($past(vld) & $past(glb))));

  p_flush_page_r8: assert property (@(posedge clk) disable iff (rst)
    (mnt_op == 3'd4) |=> ((vld & ~$past(vld)) == '0 && $stable(ptr)));

  p_peek_hold_r9: assert property (@(posedge clk) disable iff (rst)
    (mnt_op == 3'd5) |=> (pk_vld && pk_idx == $past(ptr) && $stable(ptr)));

endmodule

bind asid_tlb asid_tlb_chk #(.DEPTH(DEPTH)) u_chk (
  .clk    (clk),
  .rst    (rst),
  .mnt_op (mnt_op),
  .rs_vld (rs_vld),
  .rs_hit (rs_hit),
  .rs_idx (rs_idx),
  .pk_vld (pk_vld),
  .pk_idx (pk_idx),
  .vld    (u_tags.vld_q),
  .glb    (u_tags.glb_q),
  .ptr    (u_ptr.ptr_q)
);

// File: tb/sim_asid_tlb.sv
module sim_asid_tlb;
  localparam int CLK_PERIOD = 10;
  localparam int DEPTH  = 64;
  localparam int VPN_W  = 19;
  localparam int ASID_W = 8;
  localparam int PPN_W  = 20;
  localparam int ATTR_W = 6;
  localparam int IDX_W  = $clog2(DEPTH);

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic lk_valid = 1'b0;
  logic [VPN_W-1:0]  lk_vpn = '0;
  logic [ASID_W-1:0] lk_asid = '0;
  logic [2:0]        mnt_op = '0;
  logic [VPN_W-1:0]  mnt_vpn = '0;
  logic [ASID_W-1:0] mnt_asid = '0;
  logic              mnt_glb = 1'b0;
  logic [PPN_W-1:0]  mnt_ppn = '0;
  logic [ATTR_W-1:0] mnt_attr = '0;
  logic rs_vld, rs_hit, pk_vld, pk_used, pk_glb;
  logic [IDX_W-1:0]  rs_idx, pk_idx;
  logic [PPN_W-1:0]  rs_ppn, pk_ppn;
  logic [ATTR_W-1:0] rs_attr, pk_attr;
  logic [VPN_W-1:0]  pk_vpn;
  logic [ASID_W-1:0] pk_asid;

  always #(CLK_PERIOD / 2) clk = ~clk;

  asid_tlb #(.DEPTH(DEPTH), .VPN_W(VPN_W), .ASID_W(ASID_W),
             .PPN_W(PPN_W), .ATTR_W(ATTR_W)) u0 (
    .clk(clk), .rst(rst), .lk_valid(lk_valid), .lk_vpn(lk_vpn), .lk_asid(lk_asid),
    .mnt_op(mnt_op), .mnt_vpn(mnt_vpn), .mnt_asid(mnt_asid), .mnt_glb(mnt_glb),
    .mnt_ppn(mnt_ppn), .mnt_attr(mnt_attr),
    .rs_vld(rs_vld), .rs_hit(rs_hit), .rs_idx(rs_idx), .rs_ppn(rs_ppn), .rs_attr(rs_attr),
    .pk_vld(pk_vld), .pk_idx(pk_idx), .pk_used(pk_used), .pk_vpn(pk_vpn),
    .pk_asid(pk_asid), .pk_glb(pk_glb), .pk_ppn(pk_ppn), .pk_attr(pk_attr)
  );

  // reference state built from the requirements
  logic              m_vld  [DEPTH];
  logic [VPN_W-1:0]  m_vpn  [DEPTH];
  logic [ASID_W-1:0] m_asid [DEPTH];
  logic              m_glb  [DEPTH];
  logic [PPN_W-1:0]  m_ppn  [DEPTH];
  logic [ATTR_W-1:0] m_attr [DEPTH];
  int m_ptr = 0;

  typedef struct packed {
    logic              hit;
    logic [IDX_W-1:0]  idx;
    logic [PPN_W-1:0]  ppn;
    logic [ATTR_W-1:0] attr;
  } lk_exp_t;

  typedef struct packed {
    logic [IDX_W-1:0]  idx;
    logic              used;
    logic [VPN_W-1:0]  vpn;
    logic [ASID_W-1:0] asid;
    logic              glb;
    logic [PPN_W-1:0]  ppn;
    logic [ATTR_W-1:0] attr;
  } pk_exp_t;

  lk_exp_t lq[$];
  string   lt[$];
  pk_exp_t pq[$];
  string   pt[$];
  int n_run = 0;
  int n_fail = 0;

  function automatic logic hits(int i, logic [VPN_W-1:0] v, logic [ASID_W-1:0] a);
    return m_vld[i] && m_vpn[i] == v && (m_glb[i] || m_asid[i] == a);
  endfunction

  function automatic lk_exp_t predict(logic [VPN_W-1:0] v, logic [ASID_W-1:0] a);
    lk_exp_t e;
    e = '0;
    for (int i = DEPTH - 1; i >= 0; i--) begin
      if (hits(i, v, a)) begin
        e.hit = 1'b1; e.idx = IDX_W'(i); e.ppn = m_ppn[i]; e.attr = m_attr[i];
      end
    end
    return e;
  endfunction

  function automatic int nxt(int p);
    return (p == DEPTH - 1) ? 0 : p + 1;
  endfunction

  // one cycle of stimulus, called just after a falling edge
  task automatic step(input logic [2:0] op, input logic [VPN_W-1:0] v,
                      input logic [ASID_W-1:0] a, input logic g,
                      input logic [PPN_W-1:0] p, input logic [ATTR_W-1:0] t,
                      input logic lk, input logic [VPN_W-1:0] lv,
                      input logic [ASID_W-1:0] la, input string tag);
    pk_exp_t pe;
    mnt_op = op; mnt_vpn = v; mnt_asid = a; mnt_glb = g; mnt_ppn = p; mnt_attr = t;
    lk_valid = lk; lk_vpn = lv; lk_asid = la;
    if (lk) begin lq.push_back(predict(lv, la)); lt.push_back(tag); end
    if (op == 3'd5 || op == 3'd6) begin
      pe.idx = IDX_W'(m_ptr); pe.used = m_vld[m_ptr]; pe.vpn = m_vpn[m_ptr];
      pe.asid = m_asid[m_ptr]; pe.glb = m_glb[m_ptr]; pe.ppn = m_ppn[m_ptr];
      pe.attr = m_attr[m_ptr];
      pq.push_back(pe); pt.push_back(tag);
    end
    case (op)
      3'd1: begin
        m_vld[m_ptr] = 1'b1; m_vpn[m_ptr] = v; m_asid[m_ptr] = a; m_glb[m_ptr] = g;
        m_ppn[m_ptr] = p; m_attr[m_ptr] = t; m_ptr = nxt(m_ptr);
      end
      3'd2: begin
        for (int i = 0; i < DEPTH; i++) m_vld[i] = 1'b0;
        m_ptr = 0;
      end
      3'd3: for (int i = 0; i < DEPTH; i++) if (!m_glb[i]) m_vld[i] = 1'b0;
      3'd4: for (int i = 0; i < DEPTH; i++) if (hits(i, v, a)) m_vld[i] = 1'b0;
      3'd6: m_ptr = nxt(m_ptr);
      default: ;
    endcase
    @(negedge clk);
  endtask

  task automatic ins(input logic [VPN_W-1:0] v, input logic [ASID_W-1:0] a,
                     input logic g, input logic [PPN_W-1:0] p, input logic [ATTR_W-1:0] t);
    step(3'd1, v, a, g, p, t, 1'b0, '0, '0, "R4");
  endtask

  task automatic look(input logic [VPN_W-1:0] v, input logic [ASID_W-1:0] a, input string tag);
    step(3'd0, '0, '0, 1'b0, '0, '0, 1'b1, v, a, tag);
  endtask

  task automatic cmd(input logic [2:0] op, input logic [VPN_W-1:0] v,
                     input logic [ASID_W-1:0] a, input string tag);
    step(op, v, a, 1'b0, '0, '0, 1'b0, '0, '0, tag);
  endtask

  // monitor: pops expectations as results appear
  always @(negedge clk) begin
    if (!rst) begin
      if (rs_vld) begin
        lk_exp_t e;
        string tg;
        n_run++;
        if (lq.size() == 0) begin
          n_fail++;
          $display("FAIL R2 unexpected lookup result: got hit=%0b idx=%0d expected none", rs_hit, rs_idx);
        end else begin
          e = lq.pop_front(); tg = lt.pop_front();
          if (rs_hit !== e.hit || rs_idx !== e.idx ||
              (e.hit && (rs_ppn !== e.ppn || rs_attr !== e.attr))) begin
            n_fail++;
            $display("FAIL %s lookup: got hit=%0b idx=%0d ppn=%h attr=%h expected hit=%0b idx=%0d ppn=%h attr=%h",
                     tg, rs_hit, rs_idx, rs_ppn, rs_attr, e.hit, e.idx, e.ppn, e.attr);
          end
        end
      end else if (lq.size() > 0 && lq.size() > 1) begin
        n_run++; n_fail++;
        $display("FAIL R2 lookup result missing: got rs_vld=0 expected 1");
        void'(lq.pop_front()); void'(lt.pop_front());
      end
      if (pk_vld) begin
        pk_exp_t e;
        string tg;
        n_run++;
        if (pq.size() == 0) begin
          n_fail++;
          $display("FAIL R9 unexpected pointer read: got idx=%0d expected none", pk_idx);
        end else begin
          e = pq.pop_front(); tg = pt.pop_front();
          if (pk_idx !== e.idx || pk_used !== e.used ||
              (e.used && (pk_vpn !== e.vpn || pk_asid !== e.asid || pk_glb !== e.glb ||
                          pk_ppn !== e.ppn || pk_attr !== e.attr))) begin
            n_fail++;
            $display("FAIL %s pointer read: got idx=%0d used=%0b vpn=%h ppn=%h expected idx=%0d used=%0b vpn=%h ppn=%h",
                     tg, pk_idx, pk_used, pk_vpn, pk_ppn, e.idx, e.used, e.vpn, e.ppn);
          end
        end
      end
    end
  end

  initial begin
    #(CLK_PERIOD * 100000);
    n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    for (int i = 0; i < DEPTH; i++) begin
      m_vld[i] = 1'b0; m_vpn[i] = '0; m_asid[i] = '0; m_glb[i] = 1'b0;
      m_ppn[i] = '0; m_attr[i] = '0;
    end
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1: reset state at the outputs
    n_run++;
    if (rs_vld !== 1'b0 || pk_vld !== 1'b0) begin
      n_fail++;
      $display("FAIL R1 outputs after reset: got rs_vld=%0b pk_vld=%0b expected 0 0", rs_vld, pk_vld);
    end
    look(19'h100, 8'd3, "R1");
    cmd(3'd5, '0, '0, "R1");

    // R11: insert and lookup in the same cycle sees the old contents
    step(3'd1, 19'h100, 8'd3, 1'b0, 20'h11, 6'h01, 1'b1, 19'h100, 8'd3, "R11");
    look(19'h100, 8'd3, "R11");
    ins(19'h200, 8'd5, 1'b1, 20'h22, 6'h02);
    ins(19'h100, 8'd7, 1'b0, 20'h33, 6'h03);
    look(19'h100, 8'd7, "R2");
    look(19'h100, 8'd4, "R3");
    look(19'h200, 8'd9, "R3");
    ins(19'h100, 8'd0, 1'b1, 20'h44, 6'h04);
    look(19'h100, 8'd7, "R10");
    look(19'h100, 8'd9, "R3");
    ins(19'h200, 8'd5, 1'b0, 20'h55, 6'h05);
    look(19'h200, 8'd5, "R10");

    // R9: pointer read, with and without stepping
    cmd(3'd5, '0, '0, "R9");
    cmd(3'd6, '0, '0, "R9");
    cmd(3'd5, '0, '0, "R9");
    cmd(3'd0, '0, '0, "R9");
    cmd(3'd7, '0, '0, "R9");
    cmd(3'd5, '0, '0, "R9");

    // R8: single-page invalidation under the match rule
    cmd(3'd4, 19'h100, 8'd7, "R8");
    look(19'h100, 8'd3, "R8");
    look(19'h100, 8'd7, "R8");
    look(19'h200, 8'd9, "R8");

    // R7: drop non-global entries only
    cmd(3'd3, '0, '0, "R7");
    look(19'h100, 8'd3, "R7");
    look(19'h200, 8'd5, "R7");
    look(19'h200, 8'd9, "R7");

    // R6: drop everything, pointer back to 0
    cmd(3'd6, '0, '0, "R9");
    cmd(3'd2, '0, '0, "R6");
    look(19'h200, 8'd9, "R6");
    cmd(3'd5, '0, '0, "R6");

    // R5: fill every slot, then wrap and overwrite slot 0
    for (int i = 0; i < DEPTH; i++)
      ins(VPN_W'(19'h1000 + i), 8'd1, 1'b0, PPN_W'(20'h80000 + i * 3), ATTR_W'(i));
    for (int i = 0; i < DEPTH; i++) look(VPN_W'(19'h1000 + i), 8'd1, "R4");
    cmd(3'd5, '0, '0, "R5");
    ins(19'h3000, 8'd1, 1'b0, 20'h3abcd, 6'h3f);
    look(19'h1000, 8'd1, "R5");
    look(19'h3000, 8'd1, "R5");
    look(19'h1001, 8'd1, "R5");
    cmd(3'd5, '0, '0, "R5");
    look(19'h1001, 8'd2, "R3");
    cmd(3'd0, '0, '0, "R2");
    cmd(3'd0, '0, '0, "R2");

    n_run++;
    if (lq.size() != 0 || pq.size() != 0) begin
      n_fail++;
      $display("FAIL R2 pending results: got %0d/%0d outstanding expected 0/0", lq.size(), pq.size());
    end
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule